// File: doc/BRIEF.md
# DMA Active Channel Context Tracker

This block keeps the working context of the single channel that a multi-channel DMA engine is serving at any moment. The context is a 16-bit remaining block count, the channel index and the channel's priority level. One shared set of active registers holds it. A per-channel write-back RAM outside the block holds the counts of every channel that is not active. When the arbiter grants a channel, the block first spills the outgoing count to its RAM entry and then refills the active register from the entry of the incoming channel. A busy flag marks the window in which the active count is valid.

While a channel is active, each completed data beat lowers the count by one. When the count reaches zero the block raises a one-cycle done pulse, writes the zero back to the channel's entry and goes idle. The block also shows, for each of four priority levels, whether a request of that level is pending or executing. All of this state is readable in one 32-bit read-only status word.

The controller is a six-state machine:
- IDLE: no channel is loaded and busy is clear. A grant goes to FETCH.
- SAVE: the outgoing count is written to RAM. Always goes to FETCH.
- FETCH: the RAM read of the incoming channel is issued. Always goes to LOAD.
- LOAD: the read data is captured. A zero count goes to IDLE and any other count goes to ACTIVE.
- ACTIVE: busy is set and beats are counted. A grant goes to SAVE. A beat that takes the count from 1 to 0 goes to RETIRE.
- RETIRE: the done pulse is raised and zero is written back. Always goes to IDLE.

Grants are acted on only in IDLE and ACTIVE. Beats are acted on only in ACTIVE, and only when no grant arrives in the same cycle.

Top module: `dma_ctx_tracker`

## Requirements
- R1: After reset the status word is all zero, chan_done is 0 and wb_en is 0.
- R2: A grant while busy is clear issues no RAM write. In the cycle after the grant it issues a read (wb_en=1, wb_we=0) at the granted index. The count is loaded and busy reads 1 three cycles after the grant.
- R3: A grant while busy is set writes the active count to the outgoing channel's entry in the cycle after the grant. Busy reads 0 from the following cycle. Busy reads 1 again, with the new count loaded, four cycles after the grant.
- R4: The channel index field, status bits 12:8, shows the granted index from the cycle after the grant.
- R5: Busy rises only two cycles after a RAM read was issued, because the RAM has one cycle of read latency.
- R6: Each beat_done while busy, with no grant in that cycle, lowers the count by exactly one. Beats while busy is clear do not touch the RAM or the count.
- R7: When a beat takes the count to zero, the next cycle carries a single-cycle chan_done together with a write of 0 to that channel's entry. Busy reads 0 in the cycle after that.
- R8: If the count read for a granted channel is zero, busy is not raised and chan_done is not pulsed.
- R9: Level flag L (status bit L, L=0..3) is the OR of two terms. The first is every pend_req[c] whose channel level ch_lvl[2c+1:2c] equals L. The second is "busy and the active channel's level equals L". The active level is grant_lvl as captured with the grant, and it takes effect when the new count is loaded.
- R10: The status word is laid out as count in 31:16, busy in 15, channel index in 12:8 and level flags in 3:0. Bits 14:13 and 7:4 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| grant_vld | input | 1 | Arbiter grant strobe |
| grant_id | input | 5 | Index of the granted channel |
| grant_lvl | input | 2 | Priority level of the granted channel |
| beat_done | input | 1 | One data beat of the active channel completed |
| pend_req | input | 32 | Per-channel pending trigger requests |
| ch_lvl | input | 64 | Per-channel priority level, 2 bits per channel |
| wb_en | output | 1 | Write-back RAM access enable |
| wb_we | output | 1 | Write-back RAM write enable |
| wb_addr | output | 5 | Write-back RAM address (channel index) |
| wb_wdata | output | 16 | Count written to the RAM |
| wb_rdata | input | 16 | Count read from the RAM, valid one cycle after a read |
| chan_done | output | 1 | Active count reached zero |
| status | output | 32 | Read-only status word |

## Verification
The assertions take three things for granted. The arbiter grants only while the block is in IDLE or ACTIVE. A beat never coincides with a grant. The RAM returns read data exactly one cycle after a read. The stimulus leaves several idle cycles after every grant, so the whole save and restore sequence completes before the next grant. It raises beats only while a loaded channel is active, apart from one deliberate burst of beats while idle. The bench's RAM model is written to answer reads with the fixed one-cycle latency.

// File: rtl/dma_ctx_pkg.sv
`timescale 1ns/1ps
package dma_ctx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SAVE,
        ST_FETCH,
        ST_LOAD,
        ST_ACTIVE,
        ST_RETIRE
    } ctx_state_e;
endpackage

// File: rtl/dma_ctx_lvl.sv
`timescale 1ns/1ps
// Per-level pending/executing flags.
module dma_ctx_lvl #(
    parameter int NUM_CH = 32,
    parameter int LVL_W  = 2,
    localparam int NUM_LVL = 1 << LVL_W
) (
    input  logic [NUM_CH-1:0]       pend_req,
    input  logic [NUM_CH*LVL_W-1:0] ch_lvl,
    input  logic                    act_vld,
    input  logic [LVL_W-1:0]        act_lvl,
    output logic [NUM_LVL-1:0]      lvl_flags
);
    for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
        logic [NUM_CH-1:0] hit;
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            assign hit[c] = pend_req[c] && (ch_lvl[c*LVL_W +: LVL_W] == LVL_W'(l));
        end
        assign lvl_flags[l] = (|hit) || (act_vld && (act_lvl == LVL_W'(l)));
    end
endmodule

// File: rtl/dma_ctx_status.sv
`timescale 1ns/1ps
// Packs the active context into the 32-bit status word.
module dma_ctx_status #(
    parameter int CNT_W   = 16,
    parameter int ID_W    = 5,
    parameter int NUM_LVL = 4
) (
    input  logic [CNT_W-1:0]   cnt,
    input  logic               busy,
    input  logic [ID_W-1:0]    id,
    input  logic [NUM_LVL-1:0] lvl,
    output logic [31:0]        word
);
    localparam int CNT_LSB  = 16;
    localparam int BUSY_BIT = 15;
    localparam int ID_LSB   = 8;

    always_comb begin
        word                      = '0;
        word[CNT_LSB +: CNT_W]    = cnt;
        word[BUSY_BIT]            = busy;
        word[ID_LSB +: ID_W]      = id;
        word[NUM_LVL-1:0]         = lvl;
    end
endmodule

// File: rtl/dma_ctx_tracker.sv
`timescale 1ns/1ps
// Active channel context: save/restore against a per-channel write-back RAM.
module dma_ctx_tracker
    import dma_ctx_pkg::*;
#(
    parameter int NUM_CH = 32,
    parameter int CNT_W  = 16,
    parameter int LVL_W  = 2,
    localparam int ID_W    = $clog2(NUM_CH),
    localparam int NUM_LVL = 1 << LVL_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    grant_vld,
    input  logic [ID_W-1:0]         grant_id,
    input  logic [LVL_W-1:0]        grant_lvl,
    input  logic                    beat_done,
    input  logic [NUM_CH-1:0]       pend_req,
    input  logic [NUM_CH*LVL_W-1:0] ch_lvl,
    output logic                    wb_en,
    output logic                    wb_we,
    output logic [ID_W-1:0]         wb_addr,
    output logic [CNT_W-1:0]        wb_wdata,
    input  logic [CNT_W-1:0]        wb_rdata,
    output logic                    chan_done,
    output logic [31:0]             status
);
    ctx_state_e           state_q, state_d;
    logic [CNT_W-1:0]     act_cnt_q;
    logic [ID_W-1:0]      act_id_q, sav_id_q;
    logic [LVL_W-1:0]     act_lvl_q, nxt_lvl_q;
    logic                 grant_take;
    logic                 busy;
    logic [NUM_LVL-1:0]   lvl_flags;

    assign grant_take = grant_vld && (state_q == ST_IDLE || state_q == ST_ACTIVE);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (grant_vld) state_d = ST_FETCH;
            ST_SAVE:   state_d = ST_FETCH;
            ST_FETCH:  state_d = ST_LOAD;
            ST_LOAD:   state_d = (wb_rdata == '0) ? ST_IDLE : ST_ACTIVE;
            ST_ACTIVE: begin
                if (grant_vld)
                    state_d = ST_SAVE;
                else if (beat_done && act_cnt_q == CNT_W'(1))
                    state_d = ST_RETIRE;
            end
            ST_RETIRE: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Context registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_cnt_q <= '0;
            act_id_q  <= '0;
            sav_id_q  <= '0;
            act_lvl_q <= '0;
            nxt_lvl_q <= '0;
        end else if (grant_take) begin
            sav_id_q  <= act_id_q;
            act_id_q  <= grant_id;
            nxt_lvl_q <= grant_lvl;
        end else if (state_q == ST_LOAD) begin
            act_cnt_q <= wb_rdata;
            act_lvl_q <= nxt_lvl_q;
        end else if (state_q == ST_ACTIVE && beat_done) begin
            act_cnt_q <= act_cnt_q - CNT_W'(1);
        end
    end

    // Outputs per state
    always_comb begin
        wb_en     = 1'b0;
        wb_we     = 1'b0;
        wb_addr   = act_id_q;
        wb_wdata  = act_cnt_q;
        chan_done = 1'b0;
        busy      = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_SAVE: begin
                wb_en   = 1'b1;
                wb_we   = 1'b1;
                wb_addr = sav_id_q;
                busy    = 1'b1;
            end
            ST_FETCH: wb_en = 1'b1;
            ST_LOAD:   ;
            ST_ACTIVE: busy = 1'b1;
            ST_RETIRE: begin
                wb_en     = 1'b1;
                wb_we     = 1'b1;
                chan_done = 1'b1;
                busy      = 1'b1;
            end
            default:   ;
        endcase
    end

    dma_ctx_lvl #(.NUM_CH(NUM_CH), .LVL_W(LVL_W)) u_lvl (
        .pend_req  (pend_req),
        .ch_lvl    (ch_lvl),
        .act_vld   (busy),
        .act_lvl   (act_lvl_q),
        .lvl_flags (lvl_flags)
    );

    dma_ctx_status #(.CNT_W(CNT_W), .ID_W(ID_W), .NUM_LVL(NUM_LVL)) u_stat (
        .cnt  (act_cnt_q),
        .busy (busy),
        .id   (act_id_q),
        .lvl  (lvl_flags),
        .word (status)
    );
endmodule

// File: rtl/dma_ctx_tracker_chk.sv
`timescale 1ns/1ps
module dma_ctx_tracker_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             grant_vld,
    input logic             beat_done,
    input logic             wb_en,
    input logic             wb_we,
    input logic [CNT_W-1:0] wb_wdata,
    input logic             chan_done,
    input logic [31:0]      status
);
    // R5
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[15]) |-> $past(wb_en && !wb_we, 2));

    // R3
    busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status[15]) |-> $past(wb_en && wb_we));

    // R7
    done_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chan_done |-> (wb_en && wb_we && wb_wdata == '0));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chan_done |=> !chan_done);

    // R6
    beat_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status[15] && !wb_en && beat_done && !grant_vld)
        |=> status[31:16] == $past(status[31:16]) - 16'd1);

    // R10
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status[14:13] == 2'b00 && status[7:4] == 4'h0);
endmodule

bind dma_ctx_tracker dma_ctx_tracker_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .grant_vld (grant_vld),
    .beat_done (beat_done),
    .wb_en     (wb_en),
    .wb_we     (wb_we),
    .wb_wdata  (wb_wdata),
    .chan_done (chan_done),
    .status    (status)
);

// File: tb/dma_ctx_tracker_bench.sv
`timescale 1ns/1ps
module dma_ctx_tracker_bench;
    localparam int NUM_CH = 32;
    localparam int CNT_W  = 16;
    localparam int LVL_W  = 2;
    localparam int ID_W   = 5;

    logic                    clk = 1'b0;
    logic                    rst_n;
    logic                    grant_vld;
    logic [ID_W-1:0]         grant_id;
    logic [LVL_W-1:0]        grant_lvl;
    logic                    beat_done;
    logic [NUM_CH-1:0]       pend_req;
    logic [NUM_CH*LVL_W-1:0] ch_lvl;
    logic                    wb_en, wb_we, chan_done;
    logic [ID_W-1:0]         wb_addr;
    logic [CNT_W-1:0]        wb_wdata, wb_rdata;
    logic [31:0]             status;

    logic                    pl_we;
    logic [ID_W-1:0]         pl_addr;
    logic [CNT_W-1:0]        pl_data;
    logic [CNT_W-1:0]        mem [NUM_CH];

    int n_run  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    // Write-back RAM model, one-cycle read latency
    always @(posedge clk) begin
        if (pl_we) mem[pl_addr] <= pl_data;
        else if (wb_en) begin
            if (wb_we) mem[wb_addr] <= wb_wdata;
            else       wb_rdata <= mem[wb_addr];
        end
    end

    dma_ctx_tracker #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .LVL_W(LVL_W)) u_dma_ctx_tracker (
        .clk(clk), .rst_n(rst_n), .grant_vld(grant_vld), .grant_id(grant_id),
        .grant_lvl(grant_lvl), .beat_done(beat_done), .pend_req(pend_req),
        .ch_lvl(ch_lvl), .wb_en(wb_en), .wb_we(wb_we), .wb_addr(wb_addr),
        .wb_wdata(wb_wdata), .wb_rdata(wb_rdata), .chan_done(chan_done),
        .status(status)
    );

    // {pend_req, expected level flags}, channel c has level c[1:0]
    localparam logic [35:0] LVL_VEC [6] = '{
        {32'h0000_0000, 4'h0},
        {32'h0000_0001, 4'h1},
        {32'h0000_0020, 4'h2},
        {32'h0000_000C, 4'hC},
        {32'h8000_0000, 4'h8},
        {32'hFFFF_FFFF, 4'hF}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic preload(input int id, input int val);
        pl_we = 1'b1; pl_addr = ID_W'(id); pl_data = CNT_W'(val);
        tick();
        pl_we = 1'b0;
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    function automatic logic [31:0] sword(int cnt, bit b, int id, logic [3:0] lv);
        return {CNT_W'(cnt), b, 2'b00, ID_W'(id), 4'h0, lv};
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; grant_vld = 1'b0; grant_id = '0; grant_lvl = '0;
        beat_done = 1'b0; pend_req = '0; pl_we = 1'b0; pl_addr = '0; pl_data = '0;
        wb_rdata = '0;
        for (int c = 0; c < NUM_CH; c++) ch_lvl[c*LVL_W +: LVL_W] = LVL_W'(c);
        for (int c = 0; c < NUM_CH; c++) mem[c] = '0;
        tick();
        preload(3, 5);
        preload(7, 2);
        preload(9, 0);
        tick();
        // R1 reset state
        chk("R1 status", status, 32'h0);
        chk("R1 done", {31'h0, chan_done}, 32'h0);
        chk("R1 wb_en", {31'h0, wb_en}, 32'h0);
        rst_n = 1'b1;
        tick();

        // R9 level flags from pending requests, table walk
        for (int i = 0; i < 6; i++) begin
            pend_req = LVL_VEC[i][35:4];
            #1;
            chk("R9 table", {28'h0, status[3:0]}, {28'h0, LVL_VEC[i][3:0]});
            tick();
        end
        pend_req = '0;

        // R2 grant from idle: ch3, level 2
        grant_vld = 1'b1; grant_id = 5'd3; grant_lvl = 2'd2;
        tick();
        grant_vld = 1'b0;
        chk("R2 read issued", {29'h0, wb_en, wb_we, 1'b0}, {29'h0, 1'b1, 1'b0, 1'b0});
        chk("R2 read addr", {27'h0, wb_addr}, 32'd3);
        chk("R4 id after grant", {27'h0, status[12:8]}, 32'd3);
        tick();
        tick();
        chk("R2 R10 loaded word", status, sword(5, 1'b1, 3, 4'b0100));

        // R6 two beats
        beat_done = 1'b1;
        tick();
        tick();
        beat_done = 1'b0;
        chk("R6 count", {16'h0, status[31:16]}, 32'd3);

        // R3 grant while busy: ch7, level 1
        grant_vld = 1'b1; grant_id = 5'd7; grant_lvl = 2'd1;
        tick();
        grant_vld = 1'b0;
        chk("R3 save write", {30'h0, wb_en, wb_we}, 32'd3);
        chk("R3 save addr/data", {11'h0, wb_addr, wb_wdata}, {11'h0, 5'd3, 16'd3});
        chk("R4 id during save", {27'h0, status[12:8]}, 32'd7);
        chk("R3 busy during save", {31'h0, status[15]}, 32'd1);
        tick();
        chk("R3 busy after save", {31'h0, status[15]}, 32'd0);
        chk("R3 mem saved", {16'h0, mem[3]}, 32'd3);
        tick();
        chk("R5 busy low in load", {31'h0, status[15]}, 32'd0);
        tick();
        chk("R3 R9 reloaded word", status, sword(2, 1'b1, 7, 4'b0010));

        // R7 drain to zero
        beat_done = 1'b1;
        tick();
        tick();
        beat_done = 1'b0;
        chk("R7 done pulse", {31'h0, chan_done}, 32'd1);
        chk("R7 zero write", {9'h0, wb_en, wb_we, wb_addr, wb_wdata}, {9'h0, 1'b1, 1'b1, 5'd7, 16'd0});
        tick();
        chk("R7 done clears", {31'h0, chan_done}, 32'd0);
        chk("R7 busy clears", {31'h0, status[15]}, 32'd0);
        chk("R7 mem zero", {16'h0, mem[7]}, 32'd0);

        // R8 zero count channel
        grant_vld = 1'b1; grant_id = 5'd9; grant_lvl = 2'd3;
        for (int k = 0; k < 4; k++) begin
            tick();
            grant_vld = 1'b0;
            chk("R8 no done", {31'h0, chan_done}, 32'd0);
        end
        chk("R8 stays idle", {31'h0, status[15]}, 32'd0);
        chk("R8 R9 no active level", {28'h0, status[3:0]}, 32'd0);

        // R6 beats while idle are ignored
        beat_done = 1'b1;
        tick();
        chk("R6 idle no ram", {31'h0, wb_en}, 32'd0);
        tick();
        beat_done = 1'b0;
        grant_vld = 1'b1; grant_id = 5'd3; grant_lvl = 2'd0; pend_req = 32'h0000_0020;
        tick();
        grant_vld = 1'b0;
        tick();
        tick();
        chk("R6 R9 stored count intact", status, sword(3, 1'b1, 3, 4'b0011));
        pend_req = '0;
        tick();
        finish_run();
    end
endmodule